// File: doc/BRIEF.md
# Synthesizer Register Programming Sequencer

This controller programs the register file of a fractional-N frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. The host places two banks of thirteen 32-bit register images on the block's inputs. One bank holds the values for the halved comparison rate and the other holds the final values. The host then issues a start command that selects one of three write orders: power-up for a comparison rate at or below 75 MHz, power-up for a rate above 75 MHz, or a frequency update.

The sequencer walks the selected order and takes each word from the bank that the step calls for. Before shifting a word out it rewrites some fields: the address nibble, the fixed pattern of register 12, the counter-reset bit and the autocalibration bit. In the two power-up orders it also holds off for a programmable settling time before register 0 is written. While it works, `busy` is high. `done` pulses for one cycle after the last word has been latched.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset, `sclk`, `sdata`, `sle`, `busy` and `done` are all 0.
- R2: Each word is sent most significant bit first. For every bit, `sdata` holds the bit while `sclk` stays low for CLK_DIV system clocks and then high for CLK_DIV system clocks. Shifting starts in the cycle after the start is accepted, or after the settling wait.
- R3: After the 32nd bit, `sle` is high for 2*CLK_DIV clocks while `sclk` and `sdata` are 0. Between two words, all three lines are then low for 2*CLK_DIV clocks.
- R4: Bits [3:0] of every word sent are replaced by the number of the register being written.
- R5: In register 12, bits [15:4] are sent as 12'h041, so bit 10 and bit 4 are 1 and the rest of that field is 0. A timeout field (bits [31:16]) of 0 is sent as 1.
- R6: Mode 2'b00 (power-up, low rate) writes registers 12 down to 1 from the final bank, waits, then writes register 0 from the final bank. No bits are patched apart from R4 and R5.
- R7: Mode 2'b01 (power-up, high rate) writes registers 12 to 5 (final bank), 4 (halved bank), 3 (final bank) and 2 and 1 (halved bank). It then waits and writes register 0 from the halved bank with bit 21 forced to 1. Next it writes registers 4, 2 and 1 from the final bank, and finally register 0 from the final bank with bit 21 forced to 0.
- R8: Mode 2'b10 (frequency update) writes, all from the final bank and with no wait: register 10, then register 4 with bit 4 forced to 1, then registers 2 and 1, then register 0 with bit 21 forced to 0, then register 4 with bit 4 forced to 0.
- R9: The settling wait lasts WAIT_CYCLES system clocks. During the wait `busy` is 1 and all serial lines are 0.
- R10: A start while `busy` is high has no effect, whatever its mode. A start with mode 2'b11 is ignored.
- R11: In the cycle after the last load strobe ends, `done` is 1 for exactly one cycle and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled while idle |
| mode | input | 2 | Sequence select: 00 low-rate power-up, 01 high-rate power-up, 10 update, 11 none |
| img_half | input | 416 | Halved-rate images; register n is in bits [32n+31:32n] |
| img_final | input | 416 | Final images, laid out the same way |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| sle | output | 1 | Load strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is due at a fixed cycle offset from the accepted start. The first data bit appears in the cycle right after the start edge, or WAIT_CYCLES cycles later when the step begins with a wait. Each bit then takes 2*CLK_DIV cycles, the strobe and the gap take 2*CLK_DIV cycles each, and `done` follows the final strobe by one cycle. The bench builds the expected waveform of all five outputs from these counts and from the write order in the requirements, then compares it with the design at every falling edge, so a result that arrives one cycle early or late is reported.

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int CLK_DIV     = 4,
  parameter int WAIT_CYCLES = 16000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [415:0]  img_half,
  input  logic [415:0]  img_final,
  output logic          sclk,
  output logic          sdata,
  output logic          sle,
  output logic          busy,
  output logic          done
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int WW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;

  localparam logic [2:0] PT_NONE = 3'd0, PT_CRST_ON = 3'd1, PT_CRST_OFF = 3'd2,
                         PT_ACAL_ON = 3'd3, PT_ACAL_OFF = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SHIFT, S_LATCH, S_GAP} st_t;

  typedef struct packed {
    logic       last;
    logic       hold;
    logic       half;
    logic [2:0] patch;
    logic [3:0] rnum;
  } step_t;

  function automatic step_t step_info(input logic [1:0] m, input logic [4:0] i);
    step_t s;
    s = '{last: 1'b0, hold: 1'b0, half: 1'b0, patch: PT_NONE, rnum: 4'd0};
    case (m)
      2'b00: begin
        if (i < 5'd12) s.rnum = 4'(5'd12 - i);
        else begin s.rnum = 4'd0; s.hold = 1'b1; s.last = 1'b1; end
      end
      2'b01: begin
        if (i < 5'd8) s.rnum = 4'(5'd12 - i);
        else case (i)
          5'd8:  begin s.rnum = 4'd4; s.half = 1'b1; end
          5'd9:  s.rnum = 4'd3;
          5'd10: begin s.rnum = 4'd2; s.half = 1'b1; end
          5'd11: begin s.rnum = 4'd1; s.half = 1'b1; end
          5'd12: begin s.rnum = 4'd0; s.half = 1'b1; s.hold = 1'b1; s.patch = PT_ACAL_ON; end
          5'd13: s.rnum = 4'd4;
          5'd14: s.rnum = 4'd2;
          5'd15: s.rnum = 4'd1;
          default: begin s.rnum = 4'd0; s.patch = PT_ACAL_OFF; s.last = 1'b1; end
        endcase
      end
      default: begin
        case (i)
          5'd0: s.rnum = 4'd10;
          5'd1: begin s.rnum = 4'd4; s.patch = PT_CRST_ON; end
          5'd2: s.rnum = 4'd2;
          5'd3: s.rnum = 4'd1;
          5'd4: begin s.rnum = 4'd0; s.patch = PT_ACAL_OFF; end
          default: begin s.rnum = 4'd4; s.patch = PT_CRST_OFF; s.last = 1'b1; end
        endcase
      end
    endcase
    return s;
  endfunction

  st_t          st;
  logic [1:0]   mode_q;
  logic [4:0]   step;
  logic [DW-1:0] div;
  logic [WW-1:0] wcnt;
  logic [5:0]   hcnt;
  logic [31:0]  raw, word;

  step_t cur, nxt, first;
  assign cur   = step_info(mode_q, step);
  assign nxt   = step_info(mode_q, step + 5'd1);
  assign first = step_info(mode, 5'd0);

  wire half_end = (div == DW'(CLK_DIV - 1));
  wire go       = start && (mode != 2'b11);

  assign raw = cur.half ? img_half[cur.rnum*32 +: 32] : img_final[cur.rnum*32 +: 32];

  always_comb begin
    word = raw;
    word[3:0] = cur.rnum;
    if (cur.rnum == 4'd12) begin
      word[15:4] = 12'h041;
      if (raw[31:16] == 16'd0) word[31:16] = 16'd1;
    end
    case (cur.patch)
      PT_CRST_ON:  word[4]  = 1'b1;
      PT_CRST_OFF: word[4]  = 1'b0;
      PT_ACAL_ON:  word[21] = 1'b1;
      PT_ACAL_OFF: word[21] = 1'b0;
      default: ;
    endcase
  end

  assign sclk  = (st == S_SHIFT) && hcnt[0];
  assign sdata = (st == S_SHIFT) && word[~hcnt[5:1]];
  assign sle   = (st == S_LATCH);
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= 2'b00; step <= '0; div <= '0;
      wcnt <= '0; hcnt <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && st != S_WAIT) div <= half_end ? '0 : div + DW'(1);
      case (st)
        S_IDLE: if (go) begin
          mode_q <= mode; step <= '0; div <= '0; hcnt <= '0; wcnt <= '0;
          st <= first.hold ? S_WAIT : S_SHIFT;
        end
        S_WAIT: begin
          if (wcnt == WW'(WAIT_CYCLES - 1)) begin wcnt <= '0; st <= S_SHIFT; end
          else wcnt <= wcnt + WW'(1);
        end
        S_SHIFT: if (half_end) begin
          hcnt <= hcnt + 6'd1;
          if (hcnt == 6'd63) st <= S_LATCH;
        end
        S_LATCH: if (half_end) begin
          hcnt <= (hcnt == 6'd1) ? 6'd0 : hcnt + 6'd1;
          if (hcnt == 6'd1) begin
            if (cur.last) begin st <= S_IDLE; done <= 1'b1; end
            else st <= S_GAP;
          end
        end
        S_GAP: if (half_end) begin
          hcnt <= (hcnt == 6'd1) ? 6'd0 : hcnt + 6'd1;
          if (hcnt == 6'd1) begin
            step <= step + 5'd1;
            st <= nxt.hold ? S_WAIT : S_SHIFT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sle |-> !sclk && !sdata);
  p_data_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
  p_busy_locks_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(sle));
  p_timeout_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur.rnum == 4'd12) |-> (word[31:16] != 16'd0));
  p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sclk && !sle && !sdata && busy);
endmodule

// File: tb/synth_prog_seq_test.sv
module synth_prog_seq_test;
  localparam int H  = 2;
  localparam int WT = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [415:0] img_half, img_final;
  logic sclk, sdata, sle, busy, done;
  int checks = 0, errors = 0, cyc = 0, poke = -1;

  always #4 clk = ~clk;

  synth_prog_seq #(.CLK_DIV(H), .WAIT_CYCLES(WT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .img_half(img_half), .img_final(img_final),
    .sclk(sclk), .sdata(sdata), .sle(sle), .busy(busy), .done(done));

  int q_reg[$], q_half[$], q_pat[$], q_wait[$];

  task automatic add(input int r, input int hb, input int p, input int w);
    q_reg.push_back(r); q_half.push_back(hb); q_pat.push_back(p); q_wait.push_back(w);
  endtask

  task automatic build(input int m);
    q_reg = {}; q_half = {}; q_pat = {}; q_wait = {};
    if (m == 0) begin
      for (int r = 12; r >= 1; r--) add(r, 0, 0, 0);
      add(0, 0, 0, 1);
    end else if (m == 1) begin
      for (int r = 12; r >= 5; r--) add(r, 0, 0, 0);
      add(4, 1, 0, 0); add(3, 0, 0, 0); add(2, 1, 0, 0); add(1, 1, 0, 0);
      add(0, 1, 3, 1); add(4, 0, 0, 0); add(2, 0, 0, 0); add(1, 0, 0, 0);
      add(0, 0, 4, 0);
    end else begin
      add(10, 0, 0, 0); add(4, 0, 1, 0); add(2, 0, 0, 0); add(1, 0, 0, 0);
      add(0, 0, 4, 0); add(4, 0, 2, 0);
    end
  endtask

  function automatic logic [31:0] exp_word(input int r, input int hb, input int p);
    logic [31:0] w;
    w = hb ? img_half[r*32 +: 32] : img_final[r*32 +: 32];
    w[3:0] = 4'(r);
    if (r == 12) begin
      w[15:4] = 12'b0000_0100_0001;
      if (w[31:16] == 16'd0) w[31:16] = 16'd1;
    end
    if (p == 1) w[4] = 1'b1;
    if (p == 2) w[4] = 1'b0;
    if (p == 3) w[21] = 1'b1;
    if (p == 4) w[21] = 1'b0;
    return w;
  endfunction

  task automatic chk(input logic ec, input logic ed, input logic el,
                     input logic eb, input logic edn, input string tag);
    checks++;
    if ({sclk, sdata, sle, busy, done} !== {ec, ed, el, eb, edn}) begin
      errors++;
      $display("FAIL %s cycle %0d: sclk/sdata/sle/busy/done got %b%b%b%b%b expected %b%b%b%b%b",
               tag, cyc, sclk, sdata, sle, busy, done, ec, ed, el, eb, edn);
    end
    if (cyc == poke) begin start = 1'b1; mode = 2'b10; end
    else start = 1'b0;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run_seq(input int m, input int pk, input string tag);
    logic [31:0] w;
    build(m);
    @(negedge clk);
    mode = 2'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 0; poke = pk;
    for (int s = 0; s < q_reg.size(); s++) begin
      w = exp_word(q_reg[s], q_half[s], q_pat[s]);
      if (q_wait[s] != 0) repeat (WT) chk(0, 0, 0, 1, 0, "R9 wait");
      for (int b = 31; b >= 0; b--) begin
        repeat (H) chk(0, w[b], 0, 1, 0, {tag, " R2 R4 R5 low half"});
        repeat (H) chk(1, w[b], 0, 1, 0, {tag, " R2 R4 R5 high half"});
      end
      repeat (2*H) chk(0, 0, 1, 1, 0, "R3 strobe");
      if (s != q_reg.size() - 1) repeat (2*H) chk(0, 0, 0, 1, 0, "R3 gap");
    end
    poke = -1;
    chk(0, 0, 0, 0, 1, "R11 done");
    repeat (3) chk(0, 0, 0, 0, 0, "R11 idle after");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 13; i++) begin
      img_final[i*32 +: 32] = 32'h1357_9BDF ^ (32'(i) * 32'h0F1E_2D3C);
      img_half[i*32 +: 32]  = 32'hE8A4_6C21 ^ (32'(i) * 32'h2233_4455);
    end
    img_final[0*32 + 21] = 1'b1;
    img_half[0*32 + 21]  = 1'b0;
    img_final[4*32 + 4]  = 1'b1;
    repeat (3) @(negedge clk);
    repeat (3) chk(0, 0, 0, 0, 0, "R1 reset");
    rst_n = 1'b1;
    chk(0, 0, 0, 0, 0, "R1 after reset");

    run_seq(0, 7, "R6 R10");
    run_seq(1, -1, "R7");
    img_final[4*32 + 4] = 1'b0;
    img_final[12*32 + 16 +: 16] = 16'h0000;
    run_seq(2, 40, "R8 R10");
    run_seq(0, -1, "R6 R5 zero timeout");

    mode = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) chk(0, 0, 0, 0, 0, "R10 reserved mode");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule